// File: doc/BRIEF.md
# Display Position Address Generator

This block serves the refresh side of a character display. For each refresh request it takes a digit position and a line number and returns the display-data memory address that holds the character code for that position. A shift offset is added on the way, so the visible window can scroll over the stored text. The memory holds 80 character locations, and the locations that are not visible can hold any other data.

There are two line modes. In one-line mode, 20 digits are visible and the window scrolls over all 80 locations. In two-line mode, each line shows 20 digits. Line one is based at 0x00 and line two at 0x40. Each line scrolls and wraps inside its own window of 40 locations. Shift-left, shift-right and return-home pulses change the offset, and changing the line mode clears it. The address is registered and appears one clock after the request.

Top module: `disp_addr_gen`

## Requirements
- R1: After reset, addr_valid is 0, addr is 0 and the shift offset is zero, so digit index 0 of the first line maps to 0x00.
- R2: In one-line mode (two_line_mode = 0) with no shift, digit index d (0 for the leftmost digit, up to 19) maps to address d, which covers 0x00 to 0x13.
- R3: In one-line mode, one shift_right pulse from zero offset makes digit index 0 map to 0x4F and digit index 19 map to 0x12. The address is (offset + d) mod 80.
- R4: In one-line mode, one shift_left pulse from zero offset makes digit index 0 map to 0x01 and digit index 19 map to 0x14.
- R5: In two-line mode (two_line_mode = 1) with no shift, req_line = 0 maps digit d to d, and req_line = 1 maps it to 0x40 + d. Digit index 19 of line one is 0x13.
- R6: In two-line mode, each line wraps inside 40 locations. One shift_right pulse makes digit index 0 map to 0x27 on line one and to 0x67 on line two. One shift_left pulse makes digit index 0 map to 0x01 and 0x41, and digit index 19 map to 0x14 and 0x54.
- R7: Each accepted shift pulse moves the offset by one, modulo 80 in one-line mode and modulo 40 in two-line mode. 80 or 40 left shifts, respectively, bring the mapping back to where it started.
- R8: A go_home pulse clears the offset. It wins over any shift pulse in the same cycle.
- R9: shift_left and shift_right asserted together in one cycle leave the offset unchanged.
- R10: A cycle in which two_line_mode differs from the mode in use clears the offset. The new mode applies from the next cycle on, and any shift or home pulse in that cycle is dropped.
- R11: For a request with a valid digit, addr_valid is 1 and addr is valid on the clock edge after req_valid. The mapping uses the mode and offset in force before that edge. In a cycle without req_valid, the next addr_valid is 0 and addr keeps its value.
- R12: A request with req_digit of 20 or more gives addr_valid = 0 on the next cycle, and addr keeps its previous value.
- R13: In one-line mode, req_line has no effect on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| two_line_mode | input | 1 | Level: 0 selects one line, 1 selects two lines |
| shift_left | input | 1 | Pulse: window moves one location toward higher addresses |
| shift_right | input | 1 | Pulse: window moves one location toward lower addresses |
| go_home | input | 1 | Pulse: clear the shift offset |
| req_valid | input | 1 | Refresh request strobe |
| req_digit | input | 5 | Digit index, 0 is the leftmost digit |
| req_line | input | 1 | 0 is line one, 1 is line two |
| addr_valid | output | 1 | Address below answers the previous request |
| addr | output | 7 | Display-data memory address |

## Verification
The hardest cases to reach are offsets near the top of each modulus combined with the rightmost digits, where the sum has to wrap. In two-line mode the wrap must also stay inside the line's own window. The stimulus reaches every offset by stepping the window one left shift at a time through the full 80 or 40 positions. At each step it requests every digit on both lines. Seeded random mixes then place shifts, home pulses, conflicting pulses and mode changes between requests.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;

    // Decoded offset operation for one cycle, in priority order of decode
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_LEFT  = 3'd1,
        OP_RIGHT = 3'd2,
        OP_HOME  = 3'd3,
        OP_MODE  = 3'd4
    } shift_op_e;

endpackage

// File: rtl/dpa_cmd_decode.sv
module dpa_cmd_decode
    import disp_addr_pkg::*;
(
    input  logic      mode_in,
    input  logic      mode_q,
    input  logic      shift_left,
    input  logic      shift_right,
    input  logic      go_home,
    output shift_op_e op
);

    // Mode change first, then home, then a single shift; opposing shifts cancel
    always_comb begin
        op = OP_HOLD;
        if (mode_in != mode_q) begin
            op = OP_MODE;
        end else if (go_home) begin
            op = OP_HOME;
        end else if (shift_left && !shift_right) begin
            op = OP_LEFT;
        end else if (shift_right && !shift_left) begin
            op = OP_RIGHT;
        end
    end

endmodule

// File: rtl/dpa_offset_reg.sv
module dpa_offset_reg
    import disp_addr_pkg::*;
#(
    parameter int ONE_SPAN = 80,
    parameter int TWO_SPAN = 40,
    parameter int OW       = $clog2(ONE_SPAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  shift_op_e     op,
    input  logic          mode_in,
    output logic          mode_q,
    output logic [OW-1:0] offset_q
);

    localparam logic [OW-1:0] ONE_TOP = OW'(ONE_SPAN - 1);
    localparam logic [OW-1:0] TWO_TOP = OW'(TWO_SPAN - 1);

    typedef struct packed {
        logic          mode;
        logic [OW-1:0] offset;
    } ofs_state_t;

    ofs_state_t st_d, st_q;
    logic [OW-1:0] top_w;

    always_comb begin
        st_d  = st_q;
        top_w = st_q.mode ? TWO_TOP : ONE_TOP;
        unique case (op)
            OP_MODE: begin
                st_d.mode   = mode_in;
                st_d.offset = '0;
            end
            OP_HOME: st_d.offset = '0;
            OP_LEFT: st_d.offset = (st_q.offset == top_w) ? '0 : st_q.offset + 1'b1;
            OP_RIGHT: st_d.offset = (st_q.offset == '0) ? top_w : st_q.offset - 1'b1;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q   = st_q.mode;
    assign offset_q = st_q.offset;

endmodule

// File: rtl/dpa_addr_map.sv
module dpa_addr_map #(
    parameter int ONE_SPAN   = 80,
    parameter int TWO_SPAN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int OW         = 7,
    parameter int DW         = 5,
    parameter int AW         = 7
) (
    input  logic          mode,
    input  logic [OW-1:0] offset,
    input  logic [DW-1:0] digit,
    input  logic          line,
    output logic [AW-1:0] addr
);

    localparam int SW = AW + 1;
    localparam logic [SW-1:0] ONE_S  = SW'(ONE_SPAN);
    localparam logic [SW-1:0] TWO_S  = SW'(TWO_SPAN);
    localparam logic [AW-1:0] BASE_A = AW'(LINE2_BASE);
    // A power-of-two base at or above the window size lets an OR replace the add
    localparam bit BASE_ALIGNED = ((LINE2_BASE & (LINE2_BASE - 1)) == 0) && (LINE2_BASE >= TWO_SPAN);

    logic [SW-1:0] sum_w;
    logic [SW-1:0] span_w;
    logic [SW-1:0] wrap_w;
    logic [AW-1:0] local_w;

    always_comb begin
        sum_w   = SW'(offset) + SW'(digit);
        span_w  = mode ? TWO_S : ONE_S;
        wrap_w  = (sum_w >= span_w) ? (sum_w - span_w) : sum_w;
        local_w = wrap_w[AW-1:0];
    end

    generate
        if (BASE_ALIGNED) begin : g_or_base
            assign addr = (mode && line) ? (local_w | BASE_A) : local_w;
        end else begin : g_add_base
            assign addr = (mode && line) ? (local_w + BASE_A) : local_w;
        end
    endgenerate

endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
    import disp_addr_pkg::*;
#(
    parameter int DIGITS     = 20,
    parameter int ONE_SPAN   = 80,
    parameter int TWO_SPAN   = 40,
    parameter int LINE2_BASE = 64,
    localparam int DW = $clog2(DIGITS),
    localparam int OW = $clog2(ONE_SPAN),
    localparam int AW = $clog2((LINE2_BASE + TWO_SPAN > ONE_SPAN) ? (LINE2_BASE + TWO_SPAN) : ONE_SPAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          two_line_mode,
    input  logic          shift_left,
    input  logic          shift_right,
    input  logic          go_home,
    input  logic          req_valid,
    input  logic [DW-1:0] req_digit,
    input  logic          req_line,
    output logic          addr_valid,
    output logic [AW-1:0] addr
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } out_state_t;

    shift_op_e     op_w;
    logic          mode_q;
    logic [OW-1:0] offset_q;
    logic [AW-1:0] map_addr_w;
    logic          digit_ok_w;
    out_state_t    out_d, out_q;

    dpa_cmd_decode u_decode (
        .mode_in     (two_line_mode),
        .mode_q      (mode_q),
        .shift_left  (shift_left),
        .shift_right (shift_right),
        .go_home     (go_home),
        .op          (op_w)
    );

    dpa_offset_reg #(
        .ONE_SPAN (ONE_SPAN),
        .TWO_SPAN (TWO_SPAN),
        .OW       (OW)
    ) u_offset (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_w),
        .mode_in  (two_line_mode),
        .mode_q   (mode_q),
        .offset_q (offset_q)
    );

    dpa_addr_map #(
        .ONE_SPAN   (ONE_SPAN),
        .TWO_SPAN   (TWO_SPAN),
        .LINE2_BASE (LINE2_BASE),
        .OW         (OW),
        .DW         (DW),
        .AW         (AW)
    ) u_map (
        .mode   (mode_q),
        .offset (offset_q),
        .digit  (req_digit),
        .line   (req_line),
        .addr   (map_addr_w)
    );

    always_comb begin
        digit_ok_w  = int'(req_digit) < DIGITS;
        out_d       = out_q;
        out_d.valid = req_valid && digit_ok_w;
        if (req_valid && digit_ok_w) begin
            out_d.addr = map_addr_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_valid = out_q.valid;
    assign addr       = out_q.addr;

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter int DIGITS     = 20,
    parameter int ONE_SPAN   = 80,
    parameter int TWO_SPAN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int DW         = 5,
    parameter int OW         = 7,
    parameter int AW         = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          two_line_mode,
    input logic          shift_left,
    input logic          shift_right,
    input logic          go_home,
    input logic          req_valid,
    input logic [DW-1:0] req_digit,
    input logic          req_line,
    input logic          addr_valid,
    input logic [AW-1:0] addr,
    input logic          mode_q,
    input logic [OW-1:0] offset_q
);

    logic good_req;
    assign good_req = req_valid && (int'(req_digit) < DIGITS);

    assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        good_req |=> addr_valid);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && $stable(addr)));

    assert_bad_digit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !good_req) |=> (!addr_valid && $stable(addr)));

    assert_offset_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(offset_q) < (mode_q ? TWO_SPAN : ONE_SPAN));

    assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (two_line_mode != mode_q) |=> (offset_q == '0 && mode_q == $past(two_line_mode)));

    assert_home_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_home && two_line_mode == mode_q) |=> (offset_q == '0));

    assert_cancel_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_left && shift_right && !go_home && two_line_mode == mode_q) |=> $stable(offset_q));

    assert_one_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (good_req && !mode_q) |=> (int'(addr) < ONE_SPAN));

    assert_line_one_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (good_req && mode_q && !req_line) |=> (int'(addr) < TWO_SPAN));

    assert_line_two_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (good_req && mode_q && req_line) |=>
            (int'(addr) >= LINE2_BASE && int'(addr) < LINE2_BASE + TWO_SPAN));

endmodule

bind disp_addr_gen dpa_checker #(
    .DIGITS     (DIGITS),
    .ONE_SPAN   (ONE_SPAN),
    .TWO_SPAN   (TWO_SPAN),
    .LINE2_BASE (LINE2_BASE),
    .DW         (DW),
    .OW         (OW),
    .AW         (AW)
) u_dpa_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .two_line_mode (two_line_mode),
    .shift_left    (shift_left),
    .shift_right   (shift_right),
    .go_home       (go_home),
    .req_valid     (req_valid),
    .req_digit     (req_digit),
    .req_line      (req_line),
    .addr_valid    (addr_valid),
    .addr          (addr),
    .mode_q        (mode_q),
    .offset_q      (offset_q)
);

// File: tb/test_disp_addr_gen.sv
module test_disp_addr_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       two_line_mode = 1'b0;
    logic       shift_left = 1'b0;
    logic       shift_right = 1'b0;
    logic       go_home = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] req_digit = '0;
    logic       req_line = 1'b0;
    logic       addr_valid;
    logic [6:0] addr;

    int checks = 0;
    int errors = 0;
    int exp_off = 0;
    bit exp_mode = 1'b0;
    int last_addr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    disp_addr_gen i_disp_addr_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .two_line_mode (two_line_mode),
        .shift_left    (shift_left),
        .shift_right   (shift_right),
        .go_home       (go_home),
        .req_valid     (req_valid),
        .req_digit     (req_digit),
        .req_line      (req_line),
        .addr_valid    (addr_valid),
        .addr          (addr)
    );

    function automatic int ref_addr(bit mode, int off, int digit, bit line);
        int span;
        int w;
        span = mode ? 40 : 80;
        w = (off + digit) % span;
        return (mode && line) ? (w + 64) : w;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // One command cycle; the bench model follows the same priority order
    task automatic cmd(bit l, bit r, bit h, bit m);
        int span;
        two_line_mode = m;
        shift_left = l;
        shift_right = r;
        go_home = h;
        @(negedge clk);
        shift_left = 1'b0;
        shift_right = 1'b0;
        go_home = 1'b0;
        if (m != exp_mode) begin
            exp_mode = m;
            exp_off = 0;
        end else begin
            span = exp_mode ? 40 : 80;
            if (h) exp_off = 0;
            else if (l && !r) exp_off = (exp_off + 1) % span;
            else if (r && !l) exp_off = (exp_off + span - 1) % span;
        end
        chk("R11 idle valid", int'(addr_valid), 0);
        chk("R11 idle hold", int'(addr), last_addr);
    endtask

    // Request and return the registered address one clock later
    task automatic req(int digit, bit line, output int got, output int vld);
        req_valid = 1'b1;
        req_digit = 5'(digit);
        req_line = line;
        @(negedge clk);
        req_valid = 1'b0;
        got = int'(addr);
        vld = int'(addr_valid);
        if (vld != 0) last_addr = got;
    endtask

    task automatic req_model(string tag, int digit, bit line);
        int got;
        int vld;
        req(digit, line, got, vld);
        if (digit < 20) begin
            chk(tag, vld, 1);
            chk(tag, got, ref_addr(exp_mode, exp_off, digit, line));
        end else begin
            chk("R12 bad digit valid", vld, 0);
            chk("R12 bad digit hold", got, last_addr);
        end
    endtask

    task automatic req_fixed(string tag, int digit, bit line, int exp);
        int got;
        int vld;
        req(digit, line, got, vld);
        chk(tag, vld, 1);
        chk(tag, got, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(addr_valid), 0);
        chk("R1 reset addr", int'(addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        req_fixed("R1 home after reset", 0, 1'b0, 8'h00);

        // One-line directed cases
        req_fixed("R2 digit 19", 19, 1'b0, 8'h13);
        req_fixed("R2 digit 7", 7, 1'b0, 8'h07);
        req_fixed("R13 line ignored", 7, 1'b1, 8'h07);
        cmd(1'b0, 1'b1, 1'b0, 1'b0);
        req_fixed("R3 right d0", 0, 1'b0, 8'h4F);
        req_fixed("R3 right d19", 19, 1'b0, 8'h12);
        req_fixed("R13 right line ignored", 19, 1'b1, 8'h12);
        cmd(1'b0, 1'b0, 1'b1, 1'b0);
        req_fixed("R8 home", 0, 1'b0, 8'h00);
        cmd(1'b1, 1'b0, 1'b0, 1'b0);
        req_fixed("R4 left d0", 0, 1'b0, 8'h01);
        req_fixed("R4 left d19", 19, 1'b0, 8'h14);
        cmd(1'b1, 1'b1, 1'b0, 1'b0);
        req_fixed("R9 both shifts", 0, 1'b0, 8'h01);
        cmd(1'b1, 1'b0, 1'b1, 1'b0);
        req_fixed("R8 home beats shift", 0, 1'b0, 8'h00);
        req_model("R12 digit 20", 20, 1'b0);
        req_model("R12 digit 31", 31, 1'b0);
        cmd(1'b1, 1'b0, 1'b0, 1'b0);
        cmd(1'b1, 1'b0, 1'b0, 1'b1);
        req_fixed("R10 mode clears", 0, 1'b0, 8'h00);

        // Two-line directed cases
        req_fixed("R5 line1 d19", 19, 1'b0, 8'h13);
        req_fixed("R5 line2 d0", 0, 1'b1, 8'h40);
        cmd(1'b0, 1'b1, 1'b0, 1'b1);
        req_fixed("R6 right line1", 0, 1'b0, 8'h27);
        req_fixed("R6 right line2", 0, 1'b1, 8'h67);
        cmd(1'b1, 1'b0, 1'b0, 1'b1);
        cmd(1'b1, 1'b0, 1'b0, 1'b1);
        req_fixed("R6 left line1 d0", 0, 1'b0, 8'h01);
        req_fixed("R6 left line2 d0", 0, 1'b1, 8'h41);
        req_fixed("R6 left line1 d19", 19, 1'b0, 8'h14);
        req_fixed("R6 left line2 d19", 19, 1'b1, 8'h54);

        // Full sweep of every offset, digit and line in both modes
        for (int m = 0; m < 2; m++) begin
            cmd(1'b0, 1'b0, 1'b1, m[0]);
            cmd(1'b0, 1'b0, 1'b1, m[0]);
            for (int s = 0; s < (m == 1 ? 40 : 80); s++) begin
                for (int ln = 0; ln < 2; ln++) begin
                    for (int d = 0; d < 20; d++) begin
                        req_model(m == 1 ? "R6 sweep" : "R3 sweep", d, ln[0]);
                    end
                end
                cmd(1'b1, 1'b0, 1'b0, m[0]);
            end
            req_fixed("R7 full cycle", 0, 1'b0, 8'h00);
        end

        // Seeded random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom % 14);
            case (op)
                6: cmd(1'b1, 1'b0, 1'b0, exp_mode);
                7: cmd(1'b0, 1'b1, 1'b0, exp_mode);
                8: cmd(1'b0, 1'b0, 1'b1, exp_mode);
                9: cmd(1'b1, 1'b1, 1'b0, exp_mode);
                10: cmd(1'b1, 1'b0, 1'b1, exp_mode);
                11: cmd(1'b0, 1'b1, 1'b0, ~exp_mode);
                default: req_model("R7 random", int'($urandom % 24), 1'($urandom));
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule